// File: doc/BRIEF.md
# Sector Transfer Command Sequencer

This block runs the data phase of disk-style sector commands: single-sector read and write, and their block-based "multiple" variants. When a command is accepted it latches the task-file address and the sector count. It turns the address into a linear sector index, using either logical-block form or cylinder/head/sector form. It then alternates between a media phase and a host phase until every sector has moved. In the media phase an abstract media port is driven with a request/done handshake. In the host phase the host moves words through the sector buffer, one strobe per word.

The sequencer drives the busy and data-request status bits and a one-cycle interrupt pulse. The sequence differs between the two directions. A read raises the data request and the interrupt together, after the media has filled a block. A write first asks for data without an interrupt. After each block the write goes busy while the media commits it, and it interrupts when the next block is wanted or when the command is complete. If the media reports an error, or an address falls outside the capacity, the command stops. The task-file outputs then show the sector that failed and how many sectors were left.

Top module: `sts_seq`

## Requirements
- R1: In logical-block mode the start index is {head[3:0], cyl_hi, cyl_lo, sect}, and the media address equals that index for the first sector. Each further sector adds one.
- R2: In cylinder/head/sector mode the start index is (cyl*heads + head)*spt + sect - 1. After each sector, sect advances. When sect reaches spt it returns to 1 and head advances. When head reaches heads-1 it returns to 0 and cylinder advances.
- R3: `bsy` is high in the cycle after a `cmd_valid` is sampled while `bsy` and `drq` are both low. A `cmd_valid` seen while either is high has no effect.
- R4: A `tf_count` of 0 transfers 256 sectors.
- R5: For reads, after the media has filled a block, `drq` rises with `bsy` low and a one-cycle `irq` in the same cycle. `drq` falls after WORDS host strobes per sector of that block.
- R6: For writes, `drq` rises with `bsy` low and no `irq` before the first block. After each block, `drq` falls and `bsy` stays high until the media finishes. Then `irq` pulses, either with `drq` set for the next block or with `bsy` and `drq` both low at the end. `irq` is never high together with `bsy`.
- R7: `cmd_op` encoding: 0 read, 1 write, 2 read-multiple, 3 write-multiple. Multiple commands move blocks of `blk_sectors` sectors, and the last block holds count mod `blk_sectors` sectors when that is nonzero. Single commands use blocks of one sector.
- R8: A multiple command with `blk_sectors` = 0 ends with `err` and `abrt` set, one `irq`, and no media request.
- R9: A sector whose linear index is greater than or equal to `capacity` is never requested. The command ends with `err` and `abrt` set, the task file pointing at that sector, and `out_count` holding the sectors left.
- R10: `med_req` stays high with a stable `med_addr` until `med_done`. `med_write` is 1 for write commands, and `bsy` is high whenever `med_req` is high.
- R11: When the media signals `med_err` together with `med_done`, the command ends. `err` is set and `abrt` is clear. The task file holds the failing sector, and `out_count` counts the failing sector and all sectors after it.
- R12: The task-file outputs advance by one sector for each successful media transfer, so after a normal end they name the sector that follows the last one. `bsy` and `drq` are never both high.
- R13: After reset `bsy`, `drq`, `irq`, `err` and `abrt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command kind (see R7) |
| lba_mode | input | 1 | 1 selects logical-block addressing |
| tf_sect | input | 8 | Task-file sector number |
| tf_cyl_lo | input | 8 | Task-file cylinder low |
| tf_cyl_hi | input | 8 | Task-file cylinder high |
| tf_head | input | 4 | Task-file head nibble |
| tf_count | input | 8 | Sector count, 0 meaning 256 |
| blk_sectors | input | 8 | Block size for multiple commands, 0 meaning not set |
| geo_spt | input | 8 | Sectors per track |
| geo_heads | input | 5 | Number of heads |
| capacity | input | 28 | Number of addressable sectors |
| host_word | input | 1 | One buffer word moved by the host |
| med_req | output | 1 | Media request |
| med_write | output | 1 | Media request is a write |
| med_addr | output | 28 | Linear sector index for the media |
| med_done | input | 1 | Media completion |
| med_err | input | 1 | Media error, valid with med_done |
| bsy | output | 1 | Busy status |
| drq | output | 1 | Data request status |
| irq | output | 1 | One-cycle interrupt pulse |
| err | output | 1 | Error status |
| abrt | output | 1 | Aborted-command error bit |
| out_sect | output | 8 | Current sector number |
| out_cyl_lo | output | 8 | Current cylinder low |
| out_cyl_hi | output | 8 | Current cylinder high |
| out_head | output | 4 | Current head nibble |
| out_count | output | 8 | Sectors remaining |

## Verification
Both multiple directions are swept over every sector count from 1 to 6 and every block size from 1 to 4. This covers counts that divide evenly into full blocks and counts that end in a partial block. Each burst length and each interrupt count is compared with values computed from those two numbers. Separate runs cover the two address forms, including a cylinder/head/sector start that crosses a head and a cylinder boundary, and a 256-sector write-multiple run. Other runs place a media error in the middle of a block, a capacity limit at the start and in the middle of a transfer, and a multiple command with no block size. These show that the stop position and the residual count follow the failing sector, not the block boundary.

// File: rtl/sts_pkg.sv
package sts_pkg;
    typedef enum logic [1:0] {
        OP_READ       = 2'd0,
        OP_WRITE      = 2'd1,
        OP_READ_MULT  = 2'd2,
        OP_WRITE_MULT = 2'd3
    } xfer_op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CHECK = 2'd1,
        S_MEDIA = 2'd2,
        S_HOSTX = 2'd3
    } seq_state_e;
endpackage

// File: rtl/sts_lin_start.sv
module sts_lin_start #(
    parameter int LIN_W = 32
) (
    input  logic             lba_mode,
    input  logic [7:0]       sect,
    input  logic [15:0]      cyl,
    input  logic [3:0]       head,
    input  logic [7:0]       spt,
    input  logic [4:0]       heads,
    output logic [LIN_W-1:0] lin
);
    logic [LIN_W-1:0] c_w, h_w, s_w, hd_w, sp_w;

    assign c_w  = LIN_W'(cyl);
    assign h_w  = LIN_W'(head);
    assign s_w  = LIN_W'(sect);
    assign hd_w = LIN_W'(heads);
    assign sp_w = LIN_W'(spt);

    always_comb begin
        if (lba_mode) lin = LIN_W'({head, cyl, sect});
        else          lin = (c_w * hd_w + h_w) * sp_w + s_w - LIN_W'(1);
    end
endmodule

// File: rtl/sts_addr_step.sv
module sts_addr_step (
    input  logic        lba_mode,
    input  logic [7:0]  sect,
    input  logic [15:0] cyl,
    input  logic [3:0]  head,
    input  logic [7:0]  spt,
    input  logic [4:0]  heads,
    output logic [7:0]  nx_sect,
    output logic [15:0] nx_cyl,
    output logic [3:0]  nx_head
);
    logic [27:0] flat_nx;

    assign flat_nx = {head, cyl, sect} + 28'd1;

    always_comb begin
        nx_sect = sect;
        nx_cyl  = cyl;
        nx_head = head;
        if (lba_mode) begin
            {nx_head, nx_cyl, nx_sect} = flat_nx;
        end else if (sect >= spt) begin
            nx_sect = 8'd1;
            if ({1'b0, head} >= heads - 5'd1) begin
                nx_head = 4'd0;
                nx_cyl  = cyl + 16'd1;
            end else begin
                nx_head = head + 4'd1;
            end
        end else begin
            nx_sect = sect + 8'd1;
        end
    end
endmodule

// File: rtl/sts_seq.sv
module sts_seq #(
    parameter int WORDS = 256,
    parameter int LIN_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic        lba_mode,
    input  logic [7:0]  tf_sect,
    input  logic [7:0]  tf_cyl_lo,
    input  logic [7:0]  tf_cyl_hi,
    input  logic [3:0]  tf_head,
    input  logic [7:0]  tf_count,
    input  logic [7:0]  blk_sectors,
    input  logic [7:0]  geo_spt,
    input  logic [4:0]  geo_heads,
    input  logic [27:0] capacity,
    input  logic        host_word,
    output logic        med_req,
    output logic        med_write,
    output logic [27:0] med_addr,
    input  logic        med_done,
    input  logic        med_err,
    output logic        bsy,
    output logic        drq,
    output logic        irq,
    output logic        err,
    output logic        abrt,
    output logic [7:0]  out_sect,
    output logic [7:0]  out_cyl_lo,
    output logic [7:0]  out_cyl_hi,
    output logic [3:0]  out_head,
    output logic [7:0]  out_count
);
    import sts_pkg::*;

    localparam int WCW = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [WCW-1:0] WLAST = WCW'(WORDS - 1);

    typedef struct packed {
        seq_state_e       st;
        xfer_op_e         op;
        logic             lba;
        logic [7:0]       sect;
        logic [15:0]      cyl;
        logic [3:0]       head;
        logic [8:0]       rem;
        logic [8:0]       blk_n;
        logic [8:0]       left;
        logic [WCW-1:0]   wcnt;
        logic [LIN_W-1:0] lin;
        logic             bsy;
        logic             drq;
        logic             irq;
        logic             err;
        logic             abrt;
    } seq_t;

    seq_t q, d;

    logic [LIN_W-1:0] lin_start;
    logic [LIN_W-1:0] cap_ext;
    logic [7:0]       nx_sect;
    logic [15:0]      nx_cyl;
    logic [3:0]       nx_head;
    logic             is_write, is_multi;
    logic [8:0]       bs_eff, take_cur, take_next;
    logic             do_abort;

    function automatic logic [8:0] f_take(input logic [8:0] r, input logic [8:0] b);
        return (r < b) ? r : b;
    endfunction

    sts_lin_start #(.LIN_W(LIN_W)) u_lin (
        .lba_mode (q.lba),
        .sect     (q.sect),
        .cyl      (q.cyl),
        .head     (q.head),
        .spt      (geo_spt),
        .heads    (geo_heads),
        .lin      (lin_start)
    );

    sts_addr_step u_step (
        .lba_mode (q.lba),
        .sect     (q.sect),
        .cyl      (q.cyl),
        .head     (q.head),
        .spt      (geo_spt),
        .heads    (geo_heads),
        .nx_sect  (nx_sect),
        .nx_cyl   (nx_cyl),
        .nx_head  (nx_head)
    );

    assign cap_ext   = LIN_W'(capacity);
    assign is_write  = q.op[0];
    assign is_multi  = q.op[1];
    assign bs_eff    = is_multi ? {1'b0, blk_sectors} : 9'd1;
    assign take_cur  = f_take(q.rem, bs_eff);
    assign take_next = f_take(q.rem - 9'd1, bs_eff);

    always_comb begin
        d        = q;
        d.irq    = 1'b0;
        do_abort = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (cmd_valid) begin
                    d.st   = S_CHECK;
                    d.op   = xfer_op_e'(cmd_op);
                    d.lba  = lba_mode;
                    d.sect = tf_sect;
                    d.cyl  = {tf_cyl_hi, tf_cyl_lo};
                    d.head = tf_head;
                    d.rem  = (tf_count == 8'd0) ? 9'd256 : {1'b0, tf_count};
                    d.bsy  = 1'b1;
                    d.err  = 1'b0;
                    d.abrt = 1'b0;
                end
            end
            S_CHECK: begin
                if ((is_multi && blk_sectors == 8'd0) || lin_start >= cap_ext) begin
                    do_abort = 1'b1;
                end else begin
                    d.lin   = lin_start;
                    d.blk_n = take_cur;
                    d.left  = take_cur;
                    d.wcnt  = '0;
                    if (is_write) begin
                        d.st  = S_HOSTX;
                        d.bsy = 1'b0;
                        d.drq = 1'b1;
                    end else begin
                        d.st  = S_MEDIA;
                    end
                end
            end
            S_MEDIA: begin
                if (q.lin >= cap_ext) begin
                    do_abort = 1'b1;
                end else if (med_done) begin
                    if (med_err) begin
                        d.st  = S_IDLE;
                        d.bsy = 1'b0;
                        d.err = 1'b1;
                        d.irq = 1'b1;
                    end else begin
                        d.sect = nx_sect;
                        d.cyl  = nx_cyl;
                        d.head = nx_head;
                        d.lin  = q.lin + LIN_W'(1);
                        d.rem  = q.rem - 9'd1;
                        d.left = q.left - 9'd1;
                        if (q.left == 9'd1) begin
                            d.wcnt = '0;
                            if (!is_write) begin
                                d.st   = S_HOSTX;
                                d.bsy  = 1'b0;
                                d.drq  = 1'b1;
                                d.irq  = 1'b1;
                                d.left = q.blk_n;
                            end else if (q.rem == 9'd1) begin
                                d.st   = S_IDLE;
                                d.bsy  = 1'b0;
                                d.irq  = 1'b1;
                            end else begin
                                d.st    = S_HOSTX;
                                d.bsy   = 1'b0;
                                d.drq   = 1'b1;
                                d.irq   = 1'b1;
                                d.blk_n = take_next;
                                d.left  = take_next;
                            end
                        end
                    end
                end
            end
            S_HOSTX: begin
                if (host_word) begin
                    if (q.wcnt == WLAST) begin
                        d.wcnt = '0;
                        d.left = q.left - 9'd1;
                        if (q.left == 9'd1) begin
                            d.drq = 1'b0;
                            if (is_write) begin
                                d.st   = S_MEDIA;
                                d.bsy  = 1'b1;
                                d.left = q.blk_n;
                            end else if (q.rem == 9'd0) begin
                                d.st   = S_IDLE;
                            end else begin
                                d.st    = S_MEDIA;
                                d.bsy   = 1'b1;
                                d.blk_n = take_cur;
                                d.left  = take_cur;
                            end
                        end
                    end else begin
                        d.wcnt = q.wcnt + WCW'(1);
                    end
                end
            end
            default: d = q;
        endcase
        if (do_abort) begin
            d.st   = S_IDLE;
            d.bsy  = 1'b0;
            d.drq  = 1'b0;
            d.err  = 1'b1;
            d.abrt = 1'b1;
            d.irq  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign med_req    = (q.st == S_MEDIA) && (q.lin < cap_ext);
    assign med_write  = is_write;
    assign med_addr   = q.lin[27:0];
    assign bsy        = q.bsy;
    assign drq        = q.drq;
    assign irq        = q.irq;
    assign err        = q.err;
    assign abrt       = q.abrt;
    assign out_sect   = q.sect;
    assign out_cyl_lo = q.cyl[7:0];
    assign out_cyl_hi = q.cyl[15:8];
    assign out_head   = q.head;
    assign out_count  = q.rem[7:0];
endmodule

// File: rtl/sts_seq_chk.sv
module sts_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        bsy,
    input logic        drq,
    input logic        irq,
    input logic        err,
    input logic        abrt,
    input logic        med_req,
    input logic        med_done,
    input logic [27:0] med_addr
);
    p_bsy_on_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !bsy && !drq) |=> bsy);

    p_bsy_drq_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bsy && drq));

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (med_req && !med_done) |=> (med_req && $stable(med_addr)));

    p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        med_req |-> bsy);

    p_abrt_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abrt |-> err);

    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !bsy);
endmodule

bind sts_seq sts_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .bsy       (bsy),
    .drq       (drq),
    .irq       (irq),
    .err       (err),
    .abrt      (abrt),
    .med_req   (med_req),
    .med_done  (med_done),
    .med_addr  (med_addr)
);

// File: tb/tb_sts_seq.sv
`timescale 1ns/1ps
module tb_sts_seq;
    localparam int W = 4;
    localparam logic [27:0] CAP = 28'h0123460;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        lba_mode = 1'b1;
    logic [7:0]  tf_sect = 8'd0, tf_cyl_lo = 8'd0, tf_cyl_hi = 8'd0, tf_count = 8'd0;
    logic [3:0]  tf_head = 4'd0;
    logic [7:0]  blk_sectors = 8'd0;
    logic [7:0]  geo_spt = 8'd4;
    logic [4:0]  geo_heads = 5'd2;
    logic [27:0] capacity = CAP;
    logic        host_word = 1'b0;
    logic        med_req, med_write, med_done = 1'b0, med_err = 1'b0;
    logic [27:0] med_addr;
    logic        bsy, drq, irq, err, abrt;
    logic [7:0]  out_sect, out_cyl_lo, out_cyl_hi, out_count;
    logic [3:0]  out_head;

    sts_seq #(.WORDS(W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .lba_mode(lba_mode), .tf_sect(tf_sect), .tf_cyl_lo(tf_cyl_lo),
        .tf_cyl_hi(tf_cyl_hi), .tf_head(tf_head), .tf_count(tf_count),
        .blk_sectors(blk_sectors), .geo_spt(geo_spt), .geo_heads(geo_heads),
        .capacity(capacity), .host_word(host_word), .med_req(med_req),
        .med_write(med_write), .med_addr(med_addr), .med_done(med_done),
        .med_err(med_err), .bsy(bsy), .drq(drq), .irq(irq), .err(err),
        .abrt(abrt), .out_sect(out_sect), .out_cyl_lo(out_cyl_lo),
        .out_cyl_hi(out_cyl_hi), .out_head(out_head), .out_count(out_count)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0;
    logic [27:0] mlog [0:299];
    logic        mwr  [0:299];
    int          nlog = 0;
    int          dly = 0;
    logic [27:0] err_addr = 28'hFFFFFFF;
    int nirq, nwords, bsy_after;
    bit irq_early, irq_bad, burst_bad;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [27:0] out_lba();
        return {out_head, out_cyl_hi, out_cyl_lo, out_sect};
    endfunction

    // media model: completes each request after a short delay
    always @(negedge clk) begin
        if (med_done) begin
            med_done = 1'b0;
            med_err  = 1'b0;
            dly      = 0;
        end else if (med_req) begin
            if (dly == 2) begin
                med_done = 1'b1;
                med_err  = (med_addr == err_addr);
                if (nlog < 300) begin
                    mlog[nlog] = med_addr;
                    mwr[nlog]  = med_write;
                end
                nlog++;
            end else begin
                dly++;
            end
        end else begin
            dly = 0;
        end
    end

    task automatic run(input int op, input bit lm, input logic [7:0] s, input logic [15:0] c,
                       input logic [3:0] h, input logic [7:0] cnt, input logic [7:0] bs,
                       input bit poke);
        int rem_e, bse, burst, cyc, exp_b;
        bit seen_drq;
        @(negedge clk);
        cmd_op = op[1:0]; lba_mode = lm; tf_sect = s; tf_cyl_lo = c[7:0];
        tf_cyl_hi = c[15:8]; tf_head = h; tf_count = cnt; blk_sectors = bs;
        cmd_valid = 1'b1;
        nlog = 0; nirq = 0; nwords = 0; irq_early = 0; irq_bad = 0; burst_bad = 0;
        seen_drq = 0; burst = 0; cyc = 0;
        rem_e = (cnt == 0) ? 256 : int'(cnt);
        bse = (op >= 2) ? int'(bs) : 1;
        @(negedge clk);
        cmd_valid = 1'b0;
        bsy_after = bsy;
        forever begin
            if (irq) begin
                nirq++;
                if (bsy) irq_bad = 1;
                if (op[0] == 1'b0 && !drq && !err) irq_bad = 1;
            end
            if (drq && !seen_drq) begin
                seen_drq = 1;
                if (op[0] == 1'b1 && nirq > 0) irq_early = 1;
            end
            if (!drq && burst > 0) begin
                exp_b = (rem_e < bse) ? rem_e : bse;
                if (burst != exp_b * W) burst_bad = 1;
                rem_e -= exp_b;
                burst = 0;
            end
            if (!(bsy || drq) || cyc > 20000) break;
            cmd_valid = (poke && cyc == 3);
            host_word = drq;
            if (drq) begin nwords++; burst++; end
            @(negedge clk);
            cyc++;
        end
        host_word = 1'b0;
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R13", "bsy after reset", bsy, 0);
        chk("R13", "drq/irq/err/abrt after reset", {drq, irq, err, abrt}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // LBA single read, 3 sectors
        run(0, 1, 8'h56, 16'h1234, 4'h0, 8'd3, 8'd0, 0);
        chk("R3", "bsy one cycle after command", bsy_after, 1);
        chk("R1", "media accesses", nlog, 3);
        for (int i = 0; i < 3; i++) chk("R1", "lba media address", mlog[i], 28'h0123456 + i);
        chk("R5", "read irq count", nirq, 3);
        chk("R5", "read irq with drq, bsy low", irq_bad, 0);
        chk("R5", "read words", nwords, 3 * W);
        chk("R12", "address after end", out_lba(), 28'h0123459);
        chk("R10", "read marks media read", mwr[0], 0);

        // CHS read multiple, 5 sectors in blocks of 2, crosses head and cylinder
        run(2, 0, 8'd3, 16'd1, 4'd1, 8'd5, 8'd2, 0);
        chk("R2", "media accesses", nlog, 5);
        for (int i = 0; i < 5; i++) chk("R2", "chs linear index", mlog[i], 14 + i);
        chk("R7", "partial block bursts", burst_bad, 0);
        chk("R7", "block irqs", nirq, 3);
        chk("R2", "final cylinder", out_cyl_lo, 2);
        chk("R2", "final head", out_head, 0);
        chk("R2", "final sector", out_sect, 4);
        chk("R12", "count after end", out_count, 0);

        // LBA single write, 2 sectors
        run(1, 1, 8'd10, 16'd0, 4'd0, 8'd2, 8'd0, 0);
        chk("R6", "no irq before first fill", irq_early, 0);
        chk("R6", "irq never with bsy", irq_bad, 0);
        chk("R6", "write irqs", nirq, 2);
        chk("R10", "write marks media write", mwr[1], 1);
        chk("R6", "write ends clean", err, 0);

        // Write multiple, count 0 = 256 sectors, blocks of 64
        run(3, 1, 8'h00, 16'h0010, 4'd0, 8'd0, 8'd64, 0);
        chk("R4", "256 media accesses", nlog, 256);
        chk("R4", "256 sectors of words", nwords, 256 * W);
        chk("R6", "write multiple irqs", nirq, 4);
        chk("R7", "64-sector bursts", burst_bad, 0);
        chk("R4", "final address", out_lba(), 28'h0001100);

        // Multiple command with no block size
        run(2, 1, 8'd0, 16'd0, 4'd0, 8'd4, 8'd0, 0);
        chk("R8", "err", err, 1);
        chk("R8", "abrt", abrt, 1);
        chk("R8", "no media access", nlog, 0);
        chk("R8", "one irq", nirq, 1);

        // Start beyond capacity
        run(0, 1, CAP[7:0], CAP[23:8], CAP[27:24], 8'd2, 8'd0, 0);
        chk("R9", "err/abrt at start", {err, abrt}, 3);
        chk("R9", "no media access", nlog, 0);
        chk("R9", "count unchanged", out_count, 2);

        // Capacity reached mid-transfer
        run(0, 1, 8'h5E, 16'h1234, 4'h0, 8'd4, 8'd0, 0);
        chk("R9", "sectors read before limit", nlog, 2);
        chk("R9", "words before limit", nwords, 2 * W);
        chk("R9", "err/abrt mid", {err, abrt}, 3);
        chk("R9", "stop address", out_lba(), CAP);
        chk("R9", "residual count", out_count, 2);

        // Media error inside a CHS read-multiple block
        err_addr = 28'd9;
        run(2, 0, 8'd4, 16'd0, 4'd1, 8'd6, 8'd4, 0);
        err_addr = 28'hFFFFFFF;
        chk("R11", "accesses up to failure", nlog, 3);
        chk("R11", "err without abrt", {err, abrt}, 2);
        chk("R11", "failing cylinder", out_cyl_lo, 1);
        chk("R11", "failing head", out_head, 0);
        chk("R11", "failing sector", out_sect, 2);
        chk("R11", "residual count", out_count, 4);
        chk("R11", "no host words", nwords, 0);

        // Media error on second sector of a write
        err_addr = 28'd201;
        run(1, 1, 8'd200, 16'd0, 4'd0, 8'd3, 8'd0, 0);
        err_addr = 28'hFFFFFFF;
        chk("R11", "write failing address", out_lba(), 201);
        chk("R11", "write residual", out_count, 2);
        chk("R11", "write irqs", nirq, 2);

        // Command while busy is ignored
        run(0, 1, 8'd44, 16'h0001, 4'd0, 8'd2, 8'd0, 1);
        chk("R3", "accesses unaffected", nlog, 2);
        chk("R3", "still reads", mwr[1], 0);
        chk("R3", "address sequence", mlog[1], 28'd301);
        chk("R3", "no error", err, 0);

        // Sweep of multiple commands over counts and block sizes
        for (int op = 2; op <= 3; op++) begin
            for (int cnt = 1; cnt <= 6; cnt++) begin
                for (int bs = 1; bs <= 4; bs++) begin
                    bit seq_ok;
                    run(op, 1, 8'd100, 16'd0, 4'd0, cnt[7:0], bs[7:0], 0);
                    seq_ok = 1;
                    for (int i = 0; i < cnt; i++)
                        if (mlog[i] != 28'(100 + i) || mwr[i] != op[0]) seq_ok = 0;
                    chk("R7", "sweep irq count", nirq, (cnt + bs - 1) / bs);
                    chk("R7", "sweep bursts", burst_bad, 0);
                    chk("R7", "sweep words", nwords, cnt * W);
                    chk("R10", "sweep media sequence", {31'd0, seq_ok} + nlog, 1 + cnt);
                    chk("R6", "sweep irq rules", {irq_bad, irq_early}, 0);
                    chk("R12", "sweep final address", out_lba(), 100 + cnt);
                end
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule